// File: doc/BRIEF.md
# Glitch-Free Clock Output Enable Controller

This block decides whether a clock output pair toggles, sits at a static idle level, or floats. It takes two enable sources: an external enable pin and a register-side pair made of an override bit and an enable bit. It resolves which source is in charge, then sequences the output buffers. An enable request first turns the drivers on at the idle level and holds them there for a settling interval. The output then toggles, starting on a clean clock period. A disable request lets the last high pulse finish, parks the pair at the idle level, and only after that releases the drivers to high impedance.

A two-bit mode field selects single-ended or differential operation. In single-ended mode only the true pin carries the clock, and the complement pin floats. In the three differential modes both pins are driven in opposite phase. A read-back output reports the register enable bit. While the override is clear, that read-back mirrors the synchronised external pin.

The controller is one state machine with four named states:
- `ST_OFF`: drivers off.
- `ST_SETTLE`: drivers on at the idle level while a counter runs.
- `ST_RUN`: toggling.
- `ST_PARK`: one cycle at the idle level before release.

It has five named transitions:
- `OFF→SETTLE` on an enable.
- `SETTLE→RUN` when the count expires.
- `SETTLE→PARK` when the enable drops during settling.
- `RUN→PARK` on a disable.
- `PARK→OFF` always.

A gate flop clocked on the falling edge lets the clock through only in `ST_RUN`.

Top module: `clk_oe_ctrl`

## Requirements
- R1: After reset both drive enables are 0 and the read-back is 0. With the override left at 0, raising the external pin enables the output.
- R2: While the override bit is 0, the read-back equals the external pin level as it was two clock edges earlier. The register enable bit has no effect in this state.
- R3: While the override bit is 1, the external pin is ignored. The output is enabled only when the register enable bit is also 1. The read-back then shows the register enable bit with the same two-edge latency.
- R4: An enable request reaches the state machine after two synchroniser edges. The drive enables turn on at the third rising edge. The pair then holds the idle level (true pin 0, complement pin 1 in differential modes) for SETTLE_CYC clock periods with no high pulse.
- R5: The first high pulse on the true pin begins at rising edge SETTLE_CYC+4 after the request and lasts a full high phase. There is no partial pulse before it.
- R6: Mode encoding is 00 single-ended, 01, 10 and 11 differential. In mode 00 the complement drive enable is 0. In differential modes the complement pin is driven and is always the inverse of the true pin.
- R7: On a disable, the high pulse that starts at the third rising edge after the request completes in full. The pair is then at the idle level with drivers still on for the low phase. Both drive enables fall at the fourth rising edge.
- R8: If the enable drops during the settling interval, no pulse is produced. The pair goes through the parked idle level and then to high impedance, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that is gated to the output and runs the control logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| oe_pin_i | input | 1 | External enable pin (asynchronous) |
| ovr_bit_i | input | 1 | Register override bit: 1 hands control to the register enable bit |
| oe_reg_i | input | 1 | Register enable bit, used only while the override is 1 |
| mode_i | input | 2 | Output mode: 00 single-ended, 01/10/11 differential |
| out_p_o | output | 1 | True clock pin |
| out_n_o | output | 1 | Complement clock pin |
| out_p_drv_o | output | 1 | Drive enable for the true pin (0 = high impedance) |
| out_n_drv_o | output | 1 | Drive enable for the complement pin (0 = high impedance) |
| oe_rdbk_o | output | 1 | Read-back value of the register enable bit |

## Verification
The enable path is exercised through the external pin and, separately, through the override pair, including combinations in which one source asks for enable and the other must win. Random modes separate single-ended from differential complement behaviour. Random run lengths show whether parking always completes the final pulse. A directed cancel during settling distinguishes a correct abort from one that leaks a pulse or skips the parked cycle. Pin toggling while the override runs the output shows whether the pin is really ignored.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_SETTLE = 2'b01,
        ST_RUN    = 2'b10,
        ST_PARK   = 2'b11
    } oe_state_e;

    typedef enum logic [1:0] {
        MODE_SE    = 2'b00,
        MODE_DIFFA = 2'b01,
        MODE_DIFFB = 2'b10,
        MODE_DIFFC = 2'b11
    } oe_mode_e;

    function automatic logic mode_is_diff(input logic [1:0] m);
        return m != MODE_SE;
    endfunction

endpackage

// File: rtl/clk_oe_sync.sv
module clk_oe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q[s] <= '0;
            end else if (s == 0) begin
                chain_q[s] <= async_i;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_oe_fsm.sv
module clk_oe_fsm
    import clk_oe_pkg::*;
#(
    parameter int SETTLE_CYC = 500
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      pin_s_i,
    input  logic      ovr_s_i,
    input  logic      reg_s_i,
    output oe_state_e state_o,
    output logic      rdbk_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    oe_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           en_eff;

    // Source resolution: override hands control to the register bit.
    assign en_eff = ovr_s_i ? (ovr_s_i & reg_s_i) : pin_s_i;
    assign rdbk_o = ovr_s_i ? reg_s_i : pin_s_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (en_eff) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!en_eff) begin
                    state_d = ST_PARK;
                end else if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (!en_eff) state_d = ST_PARK;
            end
            ST_PARK: begin
                state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/clk_oe_drive.sv
module clk_oe_drive
    import clk_oe_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  oe_state_e state_i,
    input  logic [1:0] mode_i,
    output logic      out_p_o,
    output logic      out_n_o,
    output logic      drv_p_o,
    output logic      drv_n_o
);
    logic gate_q;
    logic diff;

    // Gate flop updates on the falling edge, while the clock is low,
    // so a high phase is never truncated at either end.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= (state_i == ST_RUN);
    end

    assign diff = mode_is_diff(mode_i);

    always_comb begin
        out_p_o = clk_i & gate_q;
        out_n_o = diff ? ~(clk_i & gate_q) : 1'b0;
        drv_p_o = 1'b0;
        unique case (state_i)
            ST_OFF:    drv_p_o = 1'b0;
            ST_SETTLE: drv_p_o = 1'b1;
            ST_RUN:    drv_p_o = 1'b1;
            ST_PARK:   drv_p_o = 1'b1;
            default:   drv_p_o = 1'b0;
        endcase
        drv_n_o = drv_p_o & diff;
    end
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl
    import clk_oe_pkg::*;
#(
    parameter int SETTLE_CYC = 500
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       oe_pin_i,
    input  logic       ovr_bit_i,
    input  logic       oe_reg_i,
    input  logic [1:0] mode_i,
    output logic       out_p_o,
    output logic       out_n_o,
    output logic       out_p_drv_o,
    output logic       out_n_drv_o,
    output logic       oe_rdbk_o
);
    logic [2:0] raw, synced;
    oe_state_e  state;

    assign raw = {oe_reg_i, ovr_bit_i, oe_pin_i};

    clk_oe_sync #(.W(3), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw),
        .sync_o  (synced)
    );

    clk_oe_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_s_i (synced[0]),
        .ovr_s_i (synced[1]),
        .reg_s_i (synced[2]),
        .state_o (state),
        .rdbk_o  (oe_rdbk_o)
    );

    clk_oe_drive u_drive (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_i (state),
        .mode_i  (mode_i),
        .out_p_o (out_p_o),
        .out_n_o (out_n_o),
        .drv_p_o (out_p_drv_o),
        .drv_n_o (out_n_drv_o)
    );
endmodule

// File: rtl/clk_oe_chk.sv
module clk_oe_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       oe_pin_i,
    input logic       ovr_bit_i,
    input logic       oe_reg_i,
    input logic [1:0] mode_i,
    input logic       out_p_o,
    input logic       out_n_o,
    input logic       out_p_drv_o,
    input logic       out_n_drv_o,
    input logic       oe_rdbk_o
);
    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              age_q <= 2'd0;
        else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
    end

    always_comb begin
        if (!rst_ni) begin
            p_off_in_reset_r1: assert (!out_p_drv_o && !out_n_drv_o);
        end
    end

    p_rdbk_pin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && !$past(ovr_bit_i, 2)) |-> oe_rdbk_o == $past(oe_pin_i, 2));

    p_rdbk_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(ovr_bit_i, 2)) |-> oe_rdbk_o == $past(oe_reg_i, 2));

    p_pulse_driven_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
        out_p_o |-> out_p_drv_o);

    p_diff_complement_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (out_p_drv_o && mode_i != 2'b00) |-> (out_n_drv_o && out_n_o == !out_p_o));

    p_se_n_float_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b00) |-> !out_n_drv_o);
endmodule

bind clk_oe_ctrl clk_oe_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .oe_pin_i    (oe_pin_i),
    .ovr_bit_i   (ovr_bit_i),
    .oe_reg_i    (oe_reg_i),
    .mode_i      (mode_i),
    .out_p_o     (out_p_o),
    .out_n_o     (out_n_o),
    .out_p_drv_o (out_p_drv_o),
    .out_n_drv_o (out_n_drv_o),
    .oe_rdbk_o   (oe_rdbk_o)
);

// File: tb/sim_clk_oe_ctrl.sv
`timescale 1ns/1ps
module sim_clk_oe_ctrl;
    localparam int N = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       ovr = 1'b0;
    logic       rg = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       out_p, out_n, drv_p, drv_n, rdbk;

    int  vec = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    clk_oe_ctrl #(.SETTLE_CYC(N)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .oe_pin_i    (pin),
        .ovr_bit_i   (ovr),
        .oe_reg_i    (rg),
        .mode_i      (mode),
        .out_p_o     (out_p),
        .out_n_o     (out_n),
        .out_p_drv_o (drv_p),
        .out_n_drv_o (drv_n),
        .oe_rdbk_o   (rdbk)
    );

    function automatic logic exp_diff(input logic [1:0] m);
        return m != 2'b00;
    endfunction

    function automatic logic exp_en(input logic o, input logic r, input logic p);
        return o ? r : p;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pos(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic neg();
        @(negedge clk);
        #1;
    endtask

    // Called at negedge+1 right after the inputs requesting enable changed.
    task automatic do_enable(input bit via_pin);
        int hi;
        pos(2);
        if (via_pin) chk("R2 rdbk follows pin", rdbk, pin);
        else         chk("R3 rdbk shows reg", rdbk, rg);
        chk("R4 drivers still off", drv_p, 1'b0);
        pos(1);
        chk("R4 true driver on", drv_p, 1'b1);
        chk("R4 idle true low", out_p, 1'b0);
        chk("R6 complement driver by mode", drv_n, exp_diff(mode));
        if (exp_diff(mode)) chk("R4 idle complement high", out_n, 1'b1);
        hi = 0;
        for (int i = 0; i < N; i++) begin
            pos(1);
            if (out_p) hi++;
        end
        chk("R4 no pulse while settling", hi == 0, 1'b1);
        pos(1);
        chk("R5 first full pulse", out_p, 1'b1);
        if (exp_diff(mode)) chk("R6 complement low", out_n, 1'b0);
        neg();
        chk("R5 pulse low phase", out_p, 1'b0);
    endtask

    task automatic run(input int cyc, input bit wiggle_pin);
        for (int i = 0; i < cyc; i++) begin
            if (wiggle_pin) pin = $urandom % 2;
            pos(1);
            chk("R6 toggling high", out_p, 1'b1);
            chk("R6 complement drive", drv_n, exp_diff(mode));
            if (exp_diff(mode)) chk("R6 complement inverse", out_n, 1'b0);
            neg();
            chk("R6 toggling low", out_p, 1'b0);
        end
    endtask

    // Called at negedge+1 right after the inputs requesting disable changed.
    task automatic do_disable();
        pos(3);
        chk("R7 last pulse completes", out_p, 1'b1);
        neg();
        chk("R7 parked low", out_p, 1'b0);
        chk("R7 still driven while parked", drv_p, 1'b1);
        if (exp_diff(mode)) chk("R7 parked complement high", out_n, 1'b1);
        pos(1);
        chk("R7 true released", drv_p, 1'b0);
        chk("R7 complement released", drv_n, 1'b0);
        pos(3);
        chk("R7 stays released", drv_p, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        pos(3);
        chk("R1 reset true drive off", drv_p, 1'b0);
        chk("R1 reset complement drive off", drv_n, 1'b0);
        chk("R1 reset rdbk", rdbk, 1'b0);
        neg();
        rst_n = 1'b1;
        pos(4);
        chk("R1 idle after reset", drv_p, 1'b0);

        // R1/R2: pin path, differential
        neg(); mode = 2'b01; pin = 1'b1;
        do_enable(1'b1);
        run(5, 1'b0);
        pin = 1'b0;
        do_disable();

        // R2: register bit without override is ignored
        neg(); rg = 1'b1;
        pos(N);
        chk("R2 reg ignored without override", drv_p, 1'b0);
        chk("R2 rdbk still pin", rdbk, 1'b0);
        neg(); rg = 1'b0;

        // R8: cancel during settling
        neg(); mode = 2'b11; pin = 1'b1;
        pos(3);
        chk("R8 settling driven", drv_p, 1'b1);
        pos(5);
        neg(); pin = 1'b0;
        pos(3);
        chk("R8 parked on cancel", drv_p, 1'b1);
        chk("R8 no pulse on cancel", out_p, 1'b0);
        pos(1);
        chk("R8 released after park", drv_p, 1'b0);
        begin
            int hi = 0;
            for (int i = 0; i < N + 8; i++) begin
                pos(1);
                if (out_p || drv_p) hi++;
            end
            chk("R8 start stays cancelled", hi == 0, 1'b1);
        end

        // R3: override with reg=0 blocks the pin
        neg(); mode = 2'b00; ovr = 1'b1; rg = 1'b0; pin = 1'b1;
        pos(N);
        chk("R3 pin ignored under override", drv_p, 1'b0);
        chk("R3 rdbk is reg", rdbk, 1'b0);
        neg(); rg = 1'b1;
        do_enable(1'b0);
        run(6, 1'b1);
        rg = 1'b0;
        do_disable();
        neg(); pin = 1'b0; ovr = 1'b0;
        pos(4);

        // Random mix
        for (int it = 0; it < 14; it++) begin
            bit path;
            neg();
            mode = 2'($urandom % 4);
            path = 1'($urandom % 2);
            if (path) begin
                ovr = 1'b1; rg = 1'b0; pin = 1'($urandom % 2);
                pos(5);
                chk("R3 blocked until reg set", drv_p, exp_en(1'b1, 1'b0, pin));
                neg(); rg = 1'b1;
                do_enable(1'b0);
                run(1 + int'($urandom % 8), 1'b1);
                rg = 1'b0;
                do_disable();
                neg(); pin = 1'b0; ovr = 1'b0;
                pos(4);
                chk("R2 back to pin control", rdbk, 1'b0);
            end else begin
                pin = 1'b1;
                do_enable(1'b1);
                run(1 + int'($urandom % 8), 1'b0);
                pin = 1'b0;
                do_disable();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule